// File: doc/BRIEF.md
# VEX Prefix Recognizer and Field Decoder

This block watches an instruction stream that arrives one byte per beat and finds out whether an instruction begins with a vector-extension prefix. A start byte of 0xC4 or 0xC5 is only a candidate. In 64-bit operation the lead byte alone settles it. In 32-bit operation the same two values are also the legacy far-pointer loads LDS and LES. The block then looks at the next byte: when its two top bits are not both set, that byte is a ModR/M and the instruction is reported as legacy.

For a prefix it unpacks the payload. It returns the register-extension bits and the extra source register number, both stored inverted in the payload and restored here. It also returns the operand-size bit, the vector length, the two-bit SIMD-prefix code and the opcode map. It rebuilds the escape map and the SIMD prefix byte (none, 0x66, 0xF3 or 0xF2) that the prefix stands for. It takes the opcode byte that follows the prefix and presents one registered record per instruction start. A start byte that is not a candidate gives a plain record that carries the byte as its opcode.

The downstream decode stage reads the record on the cycle that `rec_valid` is high. The input side never stalls.

Top module: `vex_prefix_decoder`

## Requirements
- R1: A synchronous active-high reset clears `rec_valid`, and the first byte accepted after reset is treated as an instruction start.
- R2: A start byte other than 0xC4/0xC5 gives a record with `rec_is_vex`=0, `rec_is_legacy`=0, `rec_plen`=0, `rec_opcode` equal to that byte, and every other field 0.
- R3: With `long_mode`=1, a 0xC4/0xC5 start byte is always decoded as a prefix, whatever the top bits of the following byte are.
- R4: With `long_mode`=0, when bits [7:6] of the byte after 0xC4/0xC5 are not 2'b11, the record is emitted after that byte with `rec_is_legacy`=1, `rec_is_vex`=0, `rec_opcode` equal to the lead byte, and all other fields 0.
- R5: In the 0xC5 form, one payload byte P is followed by the opcode. The fields are R=~P[7], vvvv=~P[6:3], L=P[2], pp=P[1:0]. X, B and W are 0, `rec_map`=1 (0x0F), `rec_plen`=2, and `rec_opcode` is the next byte.
- R6: In the 0xC4 form, payload bytes P1 and P2 are followed by the opcode. The fields are R=~P1[7], X=~P1[6], B=~P1[5], map select=P1[4:0] (1→0x0F, 2→0x0F38, 3→0x0F3A, shown as `rec_map` 1/2/3), W=P2[7], vvvv=~P2[6:3], L=P2[2], pp=P2[1:0], and `rec_plen`=3.
- R7: In the 0xC4 form, a map select outside 1..3 sets `rec_bad_map`=1 and `rec_map`=0. The record is still produced with all other fields decoded.
- R8: `rec_simd` gives the implied prefix byte for a prefixed record: pp 00→0x00, 01→0x66, 10→0xF3, 11→0xF2.
- R9: `rec_valid` is high for exactly one cycle, in the cycle after the final byte of the instruction start (the opcode, the ModR/M of a legacy load, or the non-candidate byte) is accepted. Beats with `in_valid` low are ignored, and no record appears in the middle of a prefix.
- R10: `long_mode` is sampled with the lead byte; a change on later beats of the same prefix has no effect on the classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Always ready for a byte |
| in_byte | input | 8 | Stream byte |
| long_mode | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| rec_valid | output | 1 | Record valid, one-cycle pulse |
| rec_is_vex | output | 1 | Instruction carries a vector prefix |
| rec_is_legacy | output | 1 | Instruction is a legacy LDS/LES |
| rec_bad_map | output | 1 | Reserved map select in the 3-byte form |
| rec_r | output | 1 | Register extension R (un-inverted) |
| rec_x | output | 1 | Index extension X (un-inverted) |
| rec_b | output | 1 | Base extension B (un-inverted) |
| rec_w | output | 1 | Operand-size bit W |
| rec_vvvv | output | 4 | Extra source register number (un-inverted) |
| rec_l | output | 1 | Vector length, 0 = 128-bit, 1 = 256-bit |
| rec_pp | output | 2 | SIMD-prefix code |
| rec_simd | output | 8 | Implied SIMD prefix byte |
| rec_map | output | 2 | Implied opcode map, 1/2/3, 0 if invalid or none |
| rec_opcode | output | 8 | Opcode byte (lead byte for a legacy load) |
| rec_plen | output | 2 | Prefix length in bytes: 0, 2 or 3 |

## Verification
The bench feeds 0xC4 and 0xC5 in 32-bit operation with follow-up bytes on both sides of the 2'b11 test. A decoder that skipped this test would report LDS/LES as prefixes, and one that applied it in 64-bit operation would call real prefixes legacy. It uses payloads whose inverted fields are not symmetric (0x45, 0xE2, 0x7D), so a missed inversion or a shifted field shows up as a wrong R, X, B or vvvv. It also sends map selects of 0 and 5, which a careless design would pass through as a map. Stalled beats, a mode flip in the middle of a prefix, and a reset part-way through a prefix check that no beat is counted twice or lost. A random stream, heavy in candidate lead bytes, is compared against the behavioural model on every cycle.

// File: rtl/vexd_pkg.sv
package vexd_pkg;

    localparam int BYTE_W   = 8;
    localparam int VREG_W   = 4;
    localparam int PP_W     = 2;
    localparam int MAP_W    = 2;
    localparam int PLEN_W   = 2;
    localparam int MSEL_W   = 5;

    localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
    localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;

    localparam logic [PLEN_W-1:0] PLEN_SHORT = 2'd2;
    localparam logic [PLEN_W-1:0] PLEN_LONG  = 2'd3;
    localparam logic [MAP_W-1:0]  MAP_0F     = 2'd1;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_PAY1  = 2'd1,
        ST_PAY2  = 2'd2,
        ST_OPC   = 2'd3
    } vexd_state_e;

    typedef struct packed {
        logic              is_vex;
        logic              is_legacy;
        logic              bad_map;
        logic              r;
        logic              x;
        logic              b;
        logic              w;
        logic [VREG_W-1:0] vvvv;
        logic              l;
        logic [PP_W-1:0]   pp;
        logic [BYTE_W-1:0] simd;
        logic [MAP_W-1:0]  map;
        logic [BYTE_W-1:0] opcode;
        logic [PLEN_W-1:0] plen;
    } vexd_rec_t;

    typedef struct packed {
        vexd_state_e state;
        logic        short_form;
        logic        mode64;
        vexd_rec_t   work;
        vexd_rec_t   out;
        logic        out_valid;
    } vexd_ctx_t;

endpackage

// File: rtl/vexd_lead_check.sv
module vexd_lead_check
    import vexd_pkg::*;
(
    input  logic [BYTE_W-1:0] lead_byte,
    output logic              is_cand,
    output logic              is_short
);
    always_comb begin
        is_short = (lead_byte == LEAD_SHORT);
        is_cand  = is_short || (lead_byte == LEAD_LONG);
    end
endmodule

// File: rtl/vexd_payload_unpack.sv
module vexd_payload_unpack
    import vexd_pkg::*;
(
    input  logic [BYTE_W-1:0] pay_byte,
    output logic              peek_ok,
    output logic              ext_r,
    output logic              ext_x,
    output logic              ext_b,
    output logic [MAP_W-1:0]  map_sel,
    output logic              map_bad,
    output logic              op_w,
    output logic [VREG_W-1:0] vreg,
    output logic              vlen,
    output logic [PP_W-1:0]   pp_code
);
    localparam int TOP = BYTE_W - 1;

    logic [MSEL_W-1:0] msel;

    always_comb begin
        // view as the leading payload byte
        peek_ok = &pay_byte[TOP -: 2];
        ext_r   = ~pay_byte[TOP];
        ext_x   = ~pay_byte[TOP-1];
        ext_b   = ~pay_byte[TOP-2];
        msel    = pay_byte[MSEL_W-1:0];
        map_bad = (msel == '0) || (msel > MSEL_W'(3));
        map_sel = map_bad ? '0 : msel[MAP_W-1:0];
        // view as the byte carrying W/vvvv/L/pp
        op_w    = pay_byte[TOP];
        vreg    = ~pay_byte[TOP-1 -: VREG_W];
        vlen    = pay_byte[PP_W];
        pp_code = pay_byte[PP_W-1:0];
    end
endmodule

// File: rtl/vexd_simd_expand.sv
module vexd_simd_expand
    import vexd_pkg::*;
(
    input  logic [PP_W-1:0]   pp_code,
    output logic [BYTE_W-1:0] simd_byte
);
    always_comb begin
        unique case (pp_code)
            2'b01:   simd_byte = 8'h66;
            2'b10:   simd_byte = 8'hF3;
            2'b11:   simd_byte = 8'hF2;
            default: simd_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/vex_prefix_decoder.sv
module vex_prefix_decoder
    import vexd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              long_mode,
    output logic              rec_valid,
    output logic              rec_is_vex,
    output logic              rec_is_legacy,
    output logic              rec_bad_map,
    output logic              rec_r,
    output logic              rec_x,
    output logic              rec_b,
    output logic              rec_w,
    output logic [VREG_W-1:0] rec_vvvv,
    output logic              rec_l,
    output logic [PP_W-1:0]   rec_pp,
    output logic [BYTE_W-1:0] rec_simd,
    output logic [MAP_W-1:0]  rec_map,
    output logic [BYTE_W-1:0] rec_opcode,
    output logic [PLEN_W-1:0] rec_plen
);
    vexd_ctx_t ctx_d, ctx_q;

    logic              lead_cand, lead_short;
    logic              peek_ok, u_r, u_x, u_b, u_bad, u_w, u_l;
    logic [MAP_W-1:0]  u_map;
    logic [VREG_W-1:0] u_vvvv;
    logic [PP_W-1:0]   u_pp;
    logic [BYTE_W-1:0] u_simd;
    logic              beat;

    vexd_lead_check i_lead (
        .lead_byte (in_byte),
        .is_cand   (lead_cand),
        .is_short  (lead_short)
    );

    vexd_payload_unpack i_unpack (
        .pay_byte (in_byte),
        .peek_ok  (peek_ok),
        .ext_r    (u_r),
        .ext_x    (u_x),
        .ext_b    (u_b),
        .map_sel  (u_map),
        .map_bad  (u_bad),
        .op_w     (u_w),
        .vreg     (u_vvvv),
        .vlen     (u_l),
        .pp_code  (u_pp)
    );

    vexd_simd_expand i_simd (
        .pp_code   (u_pp),
        .simd_byte (u_simd)
    );

    assign in_ready = 1'b1;
    assign beat     = in_valid && in_ready;

    always_comb begin
        ctx_d           = ctx_q;
        ctx_d.out_valid = 1'b0;
        if (beat) begin
            unique case (ctx_q.state)
                ST_START: begin
                    if (lead_cand) begin
                        ctx_d.work       = '0;
                        ctx_d.short_form = lead_short;
                        ctx_d.mode64     = long_mode;
                        ctx_d.state      = ST_PAY1;
                    end else begin
                        ctx_d.out        = '0;
                        ctx_d.out.opcode = in_byte;
                        ctx_d.out_valid  = 1'b1;
                    end
                end
                ST_PAY1: begin
                    if (!ctx_q.mode64 && !peek_ok) begin
                        ctx_d.out           = '0;
                        ctx_d.out.is_legacy = 1'b1;
                        ctx_d.out.opcode    = ctx_q.short_form ? LEAD_SHORT : LEAD_LONG;
                        ctx_d.out_valid     = 1'b1;
                        ctx_d.state         = ST_START;
                    end else begin
                        ctx_d.work.is_vex = 1'b1;
                        ctx_d.work.r      = u_r;
                        if (ctx_q.short_form) begin
                            ctx_d.work.vvvv = u_vvvv;
                            ctx_d.work.l    = u_l;
                            ctx_d.work.pp   = u_pp;
                            ctx_d.work.simd = u_simd;
                            ctx_d.work.map  = MAP_0F;
                            ctx_d.work.plen = PLEN_SHORT;
                            ctx_d.state     = ST_OPC;
                        end else begin
                            ctx_d.work.x       = u_x;
                            ctx_d.work.b       = u_b;
                            ctx_d.work.map     = u_map;
                            ctx_d.work.bad_map = u_bad;
                            ctx_d.work.plen    = PLEN_LONG;
                            ctx_d.state        = ST_PAY2;
                        end
                    end
                end
                ST_PAY2: begin
                    ctx_d.work.w    = u_w;
                    ctx_d.work.vvvv = u_vvvv;
                    ctx_d.work.l    = u_l;
                    ctx_d.work.pp   = u_pp;
                    ctx_d.work.simd = u_simd;
                    ctx_d.state     = ST_OPC;
                end
                default: begin
                    ctx_d.out        = ctx_q.work;
                    ctx_d.out.opcode = in_byte;
                    ctx_d.out_valid  = 1'b1;
                    ctx_d.state      = ST_START;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= '0;
        else     ctx_q <= ctx_d;
    end

    assign rec_valid     = ctx_q.out_valid;
    assign rec_is_vex    = ctx_q.out.is_vex;
    assign rec_is_legacy = ctx_q.out.is_legacy;
    assign rec_bad_map   = ctx_q.out.bad_map;
    assign rec_r         = ctx_q.out.r;
    assign rec_x         = ctx_q.out.x;
    assign rec_b         = ctx_q.out.b;
    assign rec_w         = ctx_q.out.w;
    assign rec_vvvv      = ctx_q.out.vvvv;
    assign rec_l         = ctx_q.out.l;
    assign rec_pp        = ctx_q.out.pp;
    assign rec_simd      = ctx_q.out.simd;
    assign rec_map       = ctx_q.out.map;
    assign rec_opcode    = ctx_q.out.opcode;
    assign rec_plen      = ctx_q.out.plen;
endmodule

// File: rtl/vexd_checker.sv
module vexd_checker
    import vexd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              rec_valid,
    input logic              rec_is_vex,
    input logic              rec_is_legacy,
    input logic              rec_bad_map,
    input logic              rec_x,
    input logic              rec_b,
    input logic              rec_w,
    input logic [PP_W-1:0]   rec_pp,
    input logic [BYTE_W-1:0] rec_simd,
    input logic [MAP_W-1:0]  rec_map,
    input logic [BYTE_W-1:0] rec_opcode,
    input logic [PLEN_W-1:0] rec_plen
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rec_valid); // R1

    AST_PLAIN_NO_PREFIX: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_is_vex |-> rec_plen == '0); // R2

    AST_LEGACY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_is_legacy |-> !rec_is_vex && (rec_opcode == LEAD_LONG || rec_opcode == LEAD_SHORT)); // R4

    AST_SHORT_FORM_SHAPE: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_is_vex && rec_plen == PLEN_SHORT |-> rec_map == MAP_0F && !rec_x && !rec_b && !rec_w && !rec_bad_map); // R5

    AST_PREFIX_LENGTH: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_is_vex |-> rec_plen == PLEN_SHORT || rec_plen == PLEN_LONG); // R6

    AST_BAD_MAP_SHAPE: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_bad_map |-> rec_is_vex && rec_plen == PLEN_LONG && rec_map == '0); // R7

    AST_SIMD_BYTE: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_is_vex |-> rec_simd == (rec_pp == 2'b00 ? 8'h00 : rec_pp == 2'b01 ? 8'h66 : rec_pp == 2'b10 ? 8'hF3 : 8'hF2)); // R8

    AST_RECORD_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(in_valid && in_ready)); // R9
endmodule

bind vex_prefix_decoder vexd_checker i_vexd_checker (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .rec_valid     (rec_valid),
    .rec_is_vex    (rec_is_vex),
    .rec_is_legacy (rec_is_legacy),
    .rec_bad_map   (rec_bad_map),
    .rec_x         (rec_x),
    .rec_b         (rec_b),
    .rec_w         (rec_w),
    .rec_pp        (rec_pp),
    .rec_simd      (rec_simd),
    .rec_map       (rec_map),
    .rec_opcode    (rec_opcode),
    .rec_plen      (rec_plen)
);

// File: tb/test_vex_prefix_decoder.sv
module test_vex_prefix_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       long_mode = 1'b1;
    logic       rec_valid, rec_is_vex, rec_is_legacy, rec_bad_map;
    logic       rec_r, rec_x, rec_b, rec_w, rec_l;
    logic [3:0] rec_vvvv;
    logic [1:0] rec_pp, rec_map, rec_plen;
    logic [7:0] rec_simd, rec_opcode;

    always #10 clk = ~clk;

    vex_prefix_decoder i_vex_prefix_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .long_mode(long_mode), .rec_valid(rec_valid),
        .rec_is_vex(rec_is_vex), .rec_is_legacy(rec_is_legacy),
        .rec_bad_map(rec_bad_map), .rec_r(rec_r), .rec_x(rec_x), .rec_b(rec_b),
        .rec_w(rec_w), .rec_vvvv(rec_vvvv), .rec_l(rec_l), .rec_pp(rec_pp),
        .rec_simd(rec_simd), .rec_map(rec_map), .rec_opcode(rec_opcode),
        .rec_plen(rec_plen)
    );

    typedef struct packed {
        logic vex, leg, bad, r, x, b, w;
        logic [3:0] vvvv;
        logic l;
        logic [1:0] pp;
        logic [7:0] simd;
        logic [1:0] map;
        logic [7:0] opc;
        logic [1:0] plen;
    } exp_t;

    int   checks = 0;
    int   failures = 0;
    int   ms = 0;
    logic [7:0] mlead = 8'h00;
    logic mmode = 1'b0;
    exp_t wk = '0;
    exp_t er = '0;
    logic exp_valid = 1'b0;
    logic done = 1'b0;

    function automatic logic [7:0] simd_of(input logic [1:0] pp);
        case (pp)
            2'b01:   return 8'h66;
            2'b10:   return 8'hF3;
            2'b11:   return 8'hF2;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: one step per clock edge
    always @(posedge clk) begin
        exp_valid = 1'b0;
        if (rst) begin
            ms = 0;
        end else if (in_valid) begin
            if (ms == 0) begin
                if (in_byte == 8'hC4 || in_byte == 8'hC5) begin
                    mlead = in_byte; mmode = long_mode; wk = '0; ms = 1;
                end else begin
                    er = '0; er.opc = in_byte; exp_valid = 1'b1;
                end
            end else if (ms == 1) begin
                if (!mmode && in_byte[7:6] != 2'b11) begin
                    er = '0; er.leg = 1'b1; er.opc = mlead; exp_valid = 1'b1; ms = 0;
                end else begin
                    wk.vex = 1'b1;
                    wk.r = !in_byte[7];
                    if (mlead == 8'hC5) begin
                        wk.vvvv = ~in_byte[6:3]; wk.l = in_byte[2]; wk.pp = in_byte[1:0];
                        wk.simd = simd_of(in_byte[1:0]); wk.map = 2'd1; wk.plen = 2'd2; ms = 3;
                    end else begin
                        wk.x = !in_byte[6]; wk.b = !in_byte[5];
                        if (in_byte[4:0] >= 5'd1 && in_byte[4:0] <= 5'd3) wk.map = in_byte[1:0];
                        else wk.bad = 1'b1;
                        wk.plen = 2'd3; ms = 2;
                    end
                end
            end else if (ms == 2) begin
                wk.w = in_byte[7]; wk.vvvv = ~in_byte[6:3]; wk.l = in_byte[2];
                wk.pp = in_byte[1:0]; wk.simd = simd_of(in_byte[1:0]); ms = 3;
            end else begin
                er = wk; er.opc = in_byte; exp_valid = 1'b1; ms = 0;
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(rec_valid == exp_valid, "R9 record pulse", rec_valid, exp_valid);
            if (rec_valid && exp_valid) begin
                chk(rec_is_vex == er.vex, "R3/R10 prefix class", rec_is_vex, er.vex);
                chk(rec_is_legacy == er.leg, "R4 legacy class", rec_is_legacy, er.leg);
                chk(rec_opcode == er.opc, "R2 opcode", rec_opcode, er.opc);
                chk({rec_r, rec_vvvv, rec_l, rec_pp} == {er.r, er.vvvv, er.l, er.pp},
                    "R5 common fields", {rec_r, rec_vvvv, rec_l, rec_pp}, {er.r, er.vvvv, er.l, er.pp});
                chk({rec_x, rec_b, rec_w, rec_plen} == {er.x, er.b, er.w, er.plen},
                    "R6 long-form fields", {rec_x, rec_b, rec_w, rec_plen}, {er.x, er.b, er.w, er.plen});
                chk({rec_bad_map, rec_map} == {er.bad, er.map}, "R7 map",
                    {rec_bad_map, rec_map}, {er.bad, er.map});
                chk(rec_simd == er.simd, "R8 implied prefix", rec_simd, er.simd);
            end
        end
    end

    task automatic put(input logic [7:0] b, input logic m);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; long_mode = m;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_byte = 8'hC4;
        end
    endtask

    task automatic expect_rec(input string tag, input logic vex, input logic leg,
                              input logic [7:0] opc, input logic [3:0] vvvv, input logic [7:0] simd);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(rec_valid && rec_is_vex == vex && rec_is_legacy == leg && rec_opcode == opc &&
            rec_vvvv == vvvv && rec_simd == simd, tag,
            {rec_valid, rec_is_vex, rec_is_legacy, rec_opcode, rec_vvvv, rec_simd},
            {1'b1, vex, leg, opc, vvvv, simd});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        chk(rec_valid == 1'b0, "R1 reset quiet", rec_valid, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(rec_valid == 1'b0, "R1 idle after reset", rec_valid, 0);

        // R5: short form in both modes, literal expectations
        put(8'hC5, 1); put(8'hFC, 1); put(8'h58, 1);
        expect_rec("R5 C5 FC 58", 1, 0, 8'h58, 4'h0, 8'h00);
        put(8'hC5, 0); put(8'hFC, 0); put(8'h28, 0);
        put(8'hC5, 0); put(8'hFC, 0); put(8'h29, 0);
        put(8'hC5, 1); put(8'hFA, 1); put(8'h10, 1);
        expect_rec("R8 C5 FA 10", 1, 0, 8'h10, 4'h0, 8'hF3);
        // R3: top bits clear still a prefix in 64-bit operation
        put(8'hC5, 1); put(8'h45, 1); put(8'h11, 1);
        expect_rec("R3 C5 45 11", 1, 0, 8'h11, 4'h7, 8'h66);
        // R4: legacy loads in 32-bit operation
        put(8'hC4, 0); put(8'h45, 0);
        expect_rec("R4 LES", 0, 1, 8'hC4, 4'h0, 8'h00);
        put(8'hC5, 0); put(8'h80, 0);
        expect_rec("R4 LDS", 0, 1, 8'hC5, 4'h0, 8'h00);
        // R6: three-byte forms
        put(8'hC4, 1); put(8'hE2, 1); put(8'h7D, 1); put(8'h18, 1);
        expect_rec("R6 C4 E2 7D 18", 1, 0, 8'h18, 4'h0, 8'h66);
        put(8'hC4, 0); put(8'hC3, 0); put(8'hB7, 0); put(8'h0F, 0);
        // R7: reserved map selects
        put(8'hC4, 1); put(8'hE0, 1); put(8'h78, 1); put(8'h01, 1);
        put(8'hC4, 1); put(8'h05, 1); put(8'hFF, 1); put(8'h02, 1);
        // R2: plain bytes back to back
        put(8'h90, 1); put(8'h0F, 0); put(8'hC3, 1);
        gap(1);
        // R9: stalls inside a prefix
        put(8'hC4, 1); gap(2); put(8'hE1, 1); gap(3); put(8'hF9, 1); gap(1); put(8'h6F, 1);
        gap(1);
        // R10: mode flip after the lead byte
        put(8'hC5, 0); put(8'h45, 1); put(8'h77, 1);
        put(8'hC5, 1); put(8'h45, 0); put(8'h77, 0);
        gap(1);
        // R1: reset in the middle of a prefix
        put(8'hC4, 1); put(8'hE2, 1);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        put(8'h90, 1);
        expect_rec("R1 start after mid reset", 0, 0, 8'h90, 4'h0, 8'h00);

        // random stream, rich in candidate lead bytes
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            in_valid  = ($urandom_range(0, 9) < 8);
            in_byte   = ($urandom_range(0, 9) < 4) ? ($urandom_range(0, 1) ? 8'hC4 : 8'hC5)
                                                   : 8'($urandom_range(0, 255));
            long_mode = 1'($urandom_range(0, 1));
        end
        gap(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule